// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block drives the loading of a configuration bitstream out of an external serial memory. It makes the memory's clock itself and takes one data bit on every rising edge of that clock. It controls the memory through two outputs. The first is an active-low initialisation output, whose low phase clears the memory's address pointer. The second is a completion flag, which stays low while the load runs so that the memory stays enabled, and goes high at the end so that the memory is turned off. Each bit taken in is passed on to a daisy-chain output for devices further down the chain. A counter stops the load once a set number of bits has arrived.

A load begins by itself when reset is released. It begins again whenever the active-low program input is held low for at least a minimum number of system clocks, and this also applies while a load is running: such a request abandons the current load and goes back to initialisation. The memory clock runs at one of two rates, each a fixed division of the system clock. A rate-select input chooses the rate, and the block reads it once, as each load begins.

Top module: `cfg_serial_loader`

## Requirements
- R1: While `rst` is high, `init_n` is 0, `done` is 0 and `cfg_clk` is 0.
- R2: After `rst` falls, `init_n` stays low for exactly INIT_CYCLES rising edges of `clk`. It then goes high and loading starts.
- R3: During a load, consecutive rising edges of `cfg_clk` are DIV_SLOW system clocks apart when `slow_sel` was 1 at load start, and DIV_FAST apart when it was 0. `cfg_clk` is high for half of each period. Changing `slow_sel` during a load has no effect on that load.
- R4: On each rising edge of `cfg_clk`, the block captures the value that `ser_din` has at that system clock edge.
- R5: On rising edge k of a load (k ≥ 1), `chain_dout` takes the bit captured on rising edge k-1.
- R6: After LOAD_BITS rising edges, `done` goes high at the next falling edge of `cfg_clk`. `cfg_clk` then stays low and makes no further edges, and `chain_dout` shows the last bit captured.
- R7: If `prog_n` stays low for PROG_MIN or more system clocks, the block returns to initialisation: `init_n` and `done` are low two clock edges after `prog_n` returns high, and `init_n` goes high INIT_CYCLES+2 edges after that return, even if the low lasted much longer than PROG_MIN.
- R8: Outside initialisation, a low on `prog_n` that lasts PROG_MIN-1 system clocks or fewer has no effect: a load that is running finishes normally, and a finished load keeps `done` high.
- R9: A valid program request during a load abandons it. The next load starts again from the memory's first bit and counts a full LOAD_BITS bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| prog_n | input | 1 | Asynchronous active-low program request |
| slow_sel | input | 1 | 1 selects the slow memory clock rate, 0 the fast one |
| ser_din | input | 1 | Serial data from the memory |
| cfg_clk | output | 1 | Memory clock; data is taken on its rising edge |
| init_n | output | 1 | Low during initialisation; clears the memory address pointer |
| done | output | 1 | Low while loading (memory enabled), high when the load is complete |
| chain_dout | output | 1 | Daisy-chain data, one memory-clock cycle behind the sampled input |

## Verification
On every cycle the assertions check four things: the memory clock is quiet whenever `done` is high, the bit counter never goes past its limit, `done` rises only after the full count, and a program request puts the block into initialisation on the next cycle. They also check that the rate is held for the whole load and that a held request fires only once. What the assertions cannot show is the data itself, which only the bench scenarios can. The bench uses a serial-memory model with a pointer, so it can confirm that the sampled bits reach the chain output in order, that the clock spacing is correct at both rates, that an abort restarts the data from the first bit, and that requests which are too short leave a running or finished load untouched.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_LOAD = 2'd1,
        ST_DONE = 2'd2
    } ld_state_e;

    // edge events of the generated memory clock, valid in the cycle the
    // register toggles
    typedef struct packed {
        logic rise;
        logic fall;
    } clk_evt_t;

    function automatic int half_of(input int div);
        return (div < 2) ? 1 : div / 2;
    endfunction

endpackage

// File: rtl/cfg_prog_filter.sv
module cfg_prog_filter #(
    parameter int PROG_MIN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    output logic req_low,
    output logic req_hit
);
    localparam int CW = $clog2(PROG_MIN + 1);

    logic          sync1, sync2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= prog_n;
            sync2 <= sync1;
        end
    end

    assign req_low = ~sync2;
    assign req_hit = req_low && (low_cnt == CW'(PROG_MIN - 1));

    always_ff @(posedge clk) begin
        if (rst || !req_low)
            low_cnt <= '0;
        else if (low_cnt != CW'(PROG_MIN))
            low_cnt <= low_cnt + 1'b1;
    end

    // R7: a held request fires only once
    p_single_hit_r7: assert property (@(posedge clk) disable iff (rst)
        req_hit |=> !req_hit);

endmodule

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen
    import cfg_load_pkg::*;
#(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     slow,
    output logic     cfg_clk,
    output clk_evt_t evt
);
    localparam int HF = half_of(DIV_FAST);
    localparam int HS = half_of(DIV_SLOW);
    localparam int HM = (HS > HF) ? HS : HF;
    localparam int CW = $clog2(HM + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          tick;

    assign lim      = slow ? CW'(HS - 1) : CW'(HF - 1);
    assign tick     = run && (cnt == lim);
    assign evt.rise = tick && !cfg_clk;
    assign evt.fall = tick && cfg_clk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            cfg_clk <= 1'b0;
        end else if (tick) begin
            cnt     <= '0;
            cfg_clk <= ~cfg_clk;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    // R3: the clock parks low once the sequencer stops it
    p_park_low_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> !cfg_clk);
    p_rise_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_clk) |-> $past(run));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_load_pkg::*;
#(
    parameter int LOAD_BITS   = 1024,
    parameter int INIT_CYCLES = 8,
    parameter int PROG_MIN    = 10,
    parameter int DIV_FAST    = 2,
    parameter int DIV_SLOW    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    input  logic slow_sel,
    input  logic ser_din,
    output logic cfg_clk,
    output logic init_n,
    output logic done,
    output logic chain_dout
);
    localparam int TW = $clog2(INIT_CYCLES + 1);
    localparam int BW = $clog2(LOAD_BITS + 1);

    ld_state_e     state;
    logic [TW-1:0] tmr;
    logic [BW-1:0] bit_cnt;
    logic          slow_q;
    logic          held_bit;
    logic          chain_q;
    logic          req_low, req_hit;
    clk_evt_t      evt;

    cfg_prog_filter #(.PROG_MIN(PROG_MIN)) u_filt (
        .clk(clk), .rst(rst), .prog_n(prog_n),
        .req_low(req_low), .req_hit(req_hit)
    );

    cfg_clk_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_cgen (
        .clk(clk), .rst(rst), .run(state == ST_LOAD), .slow(slow_q),
        .cfg_clk(cfg_clk), .evt(evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_INIT;
            tmr      <= '0;
            bit_cnt  <= '0;
            slow_q   <= 1'b0;
            held_bit <= 1'b0;
            chain_q  <= 1'b0;
        end else if (req_hit) begin
            state   <= ST_INIT;
            tmr     <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    bit_cnt <= '0;
                    if (req_low)
                        tmr <= '0;
                    else if (tmr == TW'(INIT_CYCLES - 1)) begin
                        tmr    <= '0;
                        slow_q <= slow_sel;
                        state  <= ST_LOAD;
                    end else
                        tmr <= tmr + 1'b1;
                end
                ST_LOAD: begin
                    if (evt.rise) begin
                        held_bit <= ser_din;
                        chain_q  <= held_bit;
                        bit_cnt  <= bit_cnt + 1'b1;
                    end
                    if (evt.fall && bit_cnt == BW'(LOAD_BITS)) begin
                        chain_q <= held_bit;
                        state   <= ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign init_n     = (state != ST_INIT);
    assign done       = (state == ST_DONE);
    assign chain_dout = chain_q;

    // R6: no memory clock activity once complete
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !cfg_clk);
    p_count_cap_r6: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= BW'(LOAD_BITS));
    p_done_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(bit_cnt) == BW'(LOAD_BITS));
    // R9: a valid request forces initialisation on the next cycle
    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        req_hit |=> (!init_n && !done));
    // R3: the latched rate cannot change within a load
    p_rate_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && $past(state) == ST_LOAD) |-> slow_q == $past(slow_q));

endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
    localparam int LB   = 24;
    localparam int INIT = 6;
    localparam int PMIN = 10;
    localparam int DF   = 2;
    localparam int DS   = 16;

    logic clk = 0;
    logic rst, prog_n, slow_sel, ser_din;
    logic cfg_clk, init_n, done, chain_dout;

    always #5 clk = ~clk;

    cfg_serial_loader #(.LOAD_BITS(LB), .INIT_CYCLES(INIT), .PROG_MIN(PMIN),
                        .DIV_FAST(DF), .DIV_SLOW(DS)) u0 (
        .clk(clk), .rst(rst), .prog_n(prog_n), .slow_sel(slow_sel),
        .ser_din(ser_din), .cfg_clk(cfg_clk), .init_n(init_n), .done(done),
        .chain_dout(chain_dout)
    );

    int checks = 0, errors = 0;
    int mchecks = 0, merrs = 0;
    int seed = 3;
    int exp_div = DF;
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int init_falls = 0;
    logic prev_clk = 0;
    logic prev_init = 1;

    function automatic logic pat(input int i, input int s);
        return logic'(((i * i + i * s + s) >> 1) & 1);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // serial memory model: pointer cleared by init low, advanced on each rise
    always @(negedge clk) begin
        if (rst) begin
            rises = 0;
        end else if (!init_n) begin
            if (prev_init) init_falls = init_falls + 1;
            rises = 0;
        end else if (cfg_clk && !prev_clk) begin
            if (done) begin
                mchecks = mchecks + 1; merrs = merrs + 1;
                $display("FAIL R6 clock rise while done act=1 exp=0");
            end
            if (rises > 0) begin
                mchecks = mchecks + 1;
                if (cyc - last_rise != exp_div) begin
                    merrs = merrs + 1;
                    $display("FAIL R3 period act=%0d exp=%0d", cyc - last_rise, exp_div);
                end
                mchecks = mchecks + 1;
                if (chain_dout !== pat(rises - 1, seed)) begin
                    merrs = merrs + 1;
                    $display("FAIL R5 chain bit %0d act=%0b exp=%0b", rises - 1,
                             chain_dout, pat(rises - 1, seed));
                end
            end
            last_rise = cyc;
            rises = rises + 1;
        end
        prev_clk  = cfg_clk;
        prev_init = init_n;
        ser_din  <= pat(rises, seed);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int w);
        @(negedge clk) prog_n = 1'b0;
        repeat (w) @(negedge clk);
        prog_n = 1'b1;
    endtask

    task automatic restart(input int w, input logic slow, input int s);
        int n;
        slow_sel = slow;
        exp_div  = slow ? DS : DF;
        seed     = s;
        pulse(w);
        repeat (2) @(negedge clk);
        chk(!init_n && !done, "R7 init after request", {init_n, done}, 0);
        n = 2;
        while (!init_n && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(n == INIT + 2, "R7 init length", n, INIT + 2);
    endtask

    task automatic wait_rises(input int k);
        int t = 0;
        while (rises < k && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic finish_load(input string tag);
        int t = 0;
        int r0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done, {tag, " R6 done"}, done, 1);
        chk(rises == LB, {tag, " R6 bit count"}, rises, LB);
        chk(chain_dout == pat(LB - 1, seed), {tag, " R4 last bit"}, chain_dout,
            pat(LB - 1, seed));
        r0 = rises;
        repeat (40) @(negedge clk);
        chk(!cfg_clk && rises == r0 && done, {tag, " R6 clock parked"}, rises, r0);
    endtask

    initial begin
        int n;
        rst = 1; prog_n = 1; slow_sel = 0;
        repeat (3) @(negedge clk);
        chk(!init_n && !done && !cfg_clk, "R1 reset state", {init_n, done, cfg_clk}, 0);
        rst = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!init_n && n < 100);
        chk(n == INIT, "R2 power-on init length", n, INIT);
        finish_load("fast");

        // short request while done: ignored
        pulse(PMIN - 1);
        repeat (20) @(negedge clk);
        chk(done && init_n, "R8 short pulse in done", {done, init_n}, 3);

        // slow reload with minimum-width request
        restart(PMIN, 1'b1, 7);
        finish_load("slow");

        // long held request still gives INIT+2
        restart(PMIN + 25, 1'b0, 11);
        finish_load("held");

        // abort during fast load
        restart(PMIN, 1'b0, 5);
        wait_rises(10);
        restart(PMIN, 1'b0, 5);
        chk(rises < 2, "R9 restart from first bit", rises, 0);
        finish_load("abort fast");

        // abort during slow load
        restart(PMIN, 1'b1, 9);
        wait_rises(7);
        restart(PMIN, 1'b1, 9);
        finish_load("abort slow R9");

        // short request during load: ignored
        restart(PMIN, 1'b1, 2);
        wait_rises(5);
        n = init_falls;
        pulse(PMIN - 1);
        finish_load("short in load");
        chk(init_falls == n, "R8 no restart in load", init_falls, n);

        // rate input changed mid-load is ignored
        restart(PMIN, 1'b0, 13);
        wait_rises(5);
        slow_sel = 1'b1;
        finish_load("rate hold R3");

        $display("  CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrs + 1);
        $finish;
    end

endmodule